// File: doc/BRIEF.md
# Programmable PWM Output with Override

This block turns a fast source clock into a pulse-width-modulated pin signal. A power-of-two prescaler divides the source by 2^m, where m is a 4-bit divide select. Each prescaler tick advances an 8-bit step counter, so one output period lasts 256 * 2^m source cycles. The output is high while the step is below an 8-bit duty value n, which gives a duty of n/256.

Two control bits sit above the modulation. A drive-high bit forces the pin to 1. A run bit, when clear, forces the pin to 0, so the pin can serve as a plain general-purpose output. A power-save input stops the modulation and holds both counters at zero. A new duty or divide value takes effect only at a period boundary, so no runt pulses appear. While the modulator is idle, it reloads both values on every clock, so the first period after it starts uses the values present in the cycle before start.

Top module: `pwm_gen`

## Requirements
- R1: With the modulator running, one output period lasts 256 * 2^m source cycles, and each duty step lasts 2^m cycles (m = div_sel, 0 to 15).
- R2: Within a period the output is high during steps 0 to n-1 and low for the rest, giving n * 2^m high cycles. The high phase comes first.
- R3: A duty value of 0 gives a constant low output. A duty value of 255 gives 255 high steps out of 256.
- R4: When drive_hi is 1, pwm_o is 1 in that same cycle, whatever run_en, sleep, div_sel or duty are.
- R5: When drive_hi is 0 and run_en is 0, pwm_o is 0. Both counters are held at zero, so a later start begins at step 0 of a new period.
- R6: When sleep is 1 and drive_hi is 0, pwm_o is 0 in the same cycle and both counters are held at zero. When sleep is released, modulation restarts at step 0.
- R7: A change of duty during a running period has no effect until the next period boundary.
- R8: A change of div_sel during a running period has no effect until the next period boundary.
- R9: While the modulator is not running (run_en is 0 or sleep is 1), duty and div_sel are loaded on every clock. The first period after start therefore uses the values present one clock before run_en rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Power-save: halts and clears the modulator |
| run_en | input | 1 | Modulation enable (low forces the pin low) |
| drive_hi | input | 1 | Force the pin high; overrides everything else |
| div_sel | input | 4 | Prescale exponent m |
| duty | input | 8 | Duty value n, high steps per period |
| pwm_o | output | 1 | PWM pin |

## Verification
The risky collisions are between a register update and the period boundary, and between an override and active modulation. To provoke the first, the bench changes duty or div_sel part way through a running period. It then counts high cycles over the rest of that period, which must follow the old value, and over the next full period, which must follow the new one. To provoke the second, sleep and drive_hi are raised in the middle of a high phase. The pin must follow the override in the very next sampled cycle, and after release the high count must show that modulation restarted from step 0.

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int DIV_W  = 4,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              run_en,
  input  logic              drive_hi,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0]  pre_cnt, pre_mask;
  logic [DUTY_W-1:0] step, n_lat;
  logic [DIV_W-1:0]  m_lat;
  logic              run, tick, wrap;

  assign run      = run_en & ~sleep;
  assign pre_mask = ~({PRE_W{1'b1}} << m_lat);
  assign tick     = (pre_cnt == pre_mask);
  assign wrap     = tick & (&step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      step    <= '0;
      n_lat   <= '0;
      m_lat   <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      step    <= '0;
      n_lat   <= duty;
      m_lat   <= div_sel;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) step <= step + 1'b1;
      if (wrap) begin
        n_lat <= duty;
        m_lat <= div_sel;
      end
    end
  end

  assign pwm_o = drive_hi | (run & (step < n_lat));
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int DIV_W  = 4,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              run_en,
  input logic              drive_hi,
  input logic              pwm_o,
  input logic              tick,
  input logic [DUTY_W-1:0] step,
  input logic [DUTY_W-1:0] n_lat,
  input logic [DIV_W-1:0]  m_lat
);
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) drive_hi |-> pwm_o); // R4
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n) (!drive_hi && !run_en) |-> !pwm_o); // R5
  AST_SLEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n) (!drive_hi && sleep) |-> !pwm_o); // R6
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> (step == '0)); // R6
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n) (!drive_hi && n_lat == '0) |-> !pwm_o); // R3
  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n) (run_en && !sleep && !(tick && &step)) |=> $stable(n_lat)); // R7
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n) (run_en && !sleep && !(tick && &step)) |=> $stable(m_lat)); // R8
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n) (run_en && !sleep && !tick) |=> $stable(step)); // R1
endmodule

bind pwm_gen pwm_gen_chk #(.DIV_W(DIV_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .run_en(run_en), .drive_hi(drive_hi),
  .pwm_o(pwm_o), .tick(tick), .step(step), .n_lat(n_lat), .m_lat(m_lat)
);

// File: tb/sim_pwm_gen.sv
`timescale 1ns/1ps
module sim_pwm_gen;
  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, run_en = 1'b0, drive_hi = 1'b0;
  logic [3:0] div_sel = '0;
  logic [7:0] duty = '0;
  logic pwm_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_gen u0 (.clk(clk), .rst_n(rst_n), .sleep(sleep), .run_en(run_en),
              .drive_hi(drive_hi), .div_sel(div_sel), .duty(duty), .pwm_o(pwm_o));

  localparam int NV = 11;
  localparam int V_FH [NV] = '{0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1};
  localparam int V_EN [NV] = '{1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 1};
  localparam int V_SL [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};
  localparam int V_M  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 2, 1, 0};
  localparam int V_N  [NV] = '{0, 1, 128, 255, 7, 100, 100, 50, 64, 3, 0};
  localparam int V_EX [NV] = '{0, 1, 128, 255, 256, 0, 0, 256, 256, 6, 256};
  localparam string V_RQ [NV] = '{"R3", "R2", "R2", "R3", "R4", "R5", "R6", "R4", "R1", "R1", "R4"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_high(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      #1;
      if (pwm_o) hi++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int fh, input int en, input int sl, input int m, input int n);
    run_en = 1'b0; sleep = 1'b0; drive_hi = 1'b0;
    div_sel = 4'(m); duty = 8'(n);
    @(negedge clk);
    drive_hi = fh[0]; run_en = en[0]; sleep = sl[0];
  endtask

  initial begin
    int h;
    run_en = 1'b1; duty = 8'd255;
    repeat (3) @(negedge clk);
    #1;
    check(pwm_o == 1'b0, "R5 reset", int'(pwm_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      setup(V_FH[v], V_EN[v], V_SL[v], V_M[v], V_N[v]);
      count_high(256 << V_M[v], h);
      check(h == V_EX[v], V_RQ[v], h, V_EX[v]);
    end

    // R9: duty loaded while idle; first period uses it
    setup(0, 0, 0, 0, 0);
    duty = 8'd40;
    @(negedge clk);
    run_en = 1'b1;
    count_high(256, h);
    check(h == 40, "R9", h, 40);

    // R7: duty change mid-period
    setup(0, 1, 0, 0, 10);
    count_high(50, h);
    check(h == 10, "R2", h, 10);
    duty = 8'd200;
    count_high(206, h);
    check(h == 0, "R7 rest of period", h, 0);
    count_high(256, h);
    check(h == 200, "R7 next period", h, 200);

    // R8: divide change mid-period
    setup(0, 1, 0, 0, 128);
    count_high(20, h);
    check(h == 20, "R2", h, 20);
    div_sel = 4'd1;
    count_high(236, h);
    check(h == 108, "R8 rest of period", h, 108);
    count_high(512, h);
    check(h == 256, "R8 next period", h, 256);

    // R6 and R4 in the middle of a high phase
    setup(0, 1, 0, 0, 128);
    count_high(10, h);
    check(h == 10, "R2", h, 10);
    sleep = 1'b1;
    count_high(5, h);
    check(h == 0, "R6 sleep low", h, 0);
    drive_hi = 1'b1;
    count_high(3, h);
    check(h == 3, "R4 high in sleep", h, 3);
    drive_hi = 1'b0; sleep = 1'b0;
    count_high(256, h);
    check(h == 128, "R6 restart", h, 128);

    // R5: run_en drop mid-period then restart from step 0
    count_high(30, h);
    run_en = 1'b0;
    count_high(4, h);
    check(h == 0, "R5 off low", h, 0);
    run_en = 1'b1;
    count_high(128, h);
    check(h == 128, "R5 restart high phase", h, 128);
    count_high(1, h);
    check(h == 0, "R2 low after n steps", h, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule